// File: doc/BRIEF.md
# I2C Clock Waveform Timer

This block turns a fast functional clock into the serial-clock waveform of an I2C master. A prescaler divides the functional clock down to an internal sampling rate. Two phase counters then measure the low and the high part of each bus-clock period in sampling ticks. Configuration inputs carry the divide ratio, a packed low-phase timing word, a packed high-phase timing word and a speed mode. Each timing word holds two byte-wide values. The outputs are an open-drain style drive-low enable for the clock line and two one-cycle strobes that mark the falling and the rising edge for the bit engine.

Each programmed phase value is the ideal length less a fixed trim. The block adds the trim back, so a phase lasts (value + trim) sampling ticks. In standard and fast mode only the lower byte of each timing word is used. The low/high split (equal halves, or roughly two thirds low) comes entirely from the programmed values. In high-speed mode the lower byte times the master-code part of the transfer. When the bit engine reports that the master code and its acknowledge have completed, the block switches to the upper byte. It returns to the lower byte on STOP. Software changes the timing only while the enable is low and raises the enable again after writing.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is applied, and while enable is low, scl_drive_low is 0 and neither tick strobe pulses.
- R2: The prescaler produces one sampling tick every (psc + 1) functional clock cycles, so every phase length is a whole multiple of psc + 1.
- R3: A low phase lasts (lo + LO_TRIM) * (psc + 1) cycles, counted from tick_fall to the next tick_rise. Here lo is the selected byte of lo_cfg and LO_TRIM defaults to 2.
- R4: A high phase lasts (hi + HI_TRIM) * (psc + 1) cycles, counted from tick_rise to the next tick_fall. Here hi is the selected byte of hi_cfg and HI_TRIM defaults to 1.
- R5: tick_fall pulses for one cycle in the cycle in which scl_drive_low first reads 1. tick_rise pulses for one cycle in the cycle in which it first reads 0. The two strobes never pulse together.
- R6: After enable rises, the line starts released. The first tick_fall comes one full high phase, (hi + HI_TRIM) * (psc + 1) cycles, after the first clock edge that sees the enable.
- R7: In standard mode (mode 0) and fast mode (mode 1), only bits 7:0 of lo_cfg and hi_cfg are used. Bits 15:8 and hs_data_go have no effect.
- R8: In high-speed mode (mode 2), phases are timed from bits 7:0 until a hs_data_go pulse. Every phase that ends after that pulse is timed from bits 15:8.
- R9: In high-speed mode, a stop_seen pulse returns timing to bits 7:0. Dropping the enable does the same.
- R10: cfg_err is 1 in any of these cases: the selected low byte is 0; the selected high byte is 0; psc is 0 in standard or fast mode; mode is 3. While cfg_err is 1 the line is released and no ticks are issued.
- R11: In high-speed mode psc = 0 is valid. The sampling tick then comes every cycle.
- R12: Dropping enable in the middle of a phase releases the line after the next clock edge. A later enable starts again from a full high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator; timing is changed only while low |
| mode | input | 2 | 0 standard, 1 fast, 2 high-speed, 3 invalid |
| psc | input | 8 | Prescaler divide ratio minus one |
| lo_cfg | input | 16 | Low-phase values: [7:0] first set, [15:8] second set |
| hi_cfg | input | 16 | High-phase values: [7:0] first set, [15:8] second set |
| hs_data_go | input | 1 | Pulse: master code and its acknowledge are done |
| stop_seen | input | 1 | Pulse: STOP condition issued |
| scl_drive_low | output | 1 | 1 pulls the clock line low, 0 releases it |
| tick_fall | output | 1 | One-cycle strobe at each falling edge |
| tick_rise | output | 1 | One-cycle strobe at each rising edge |
| cfg_err | output | 1 | Current configuration is invalid |

## Verification
The waveform is measured under three contrasting settings:
- A standard-mode setting with a ratio of three and garbage in the upper bytes. This separates a correct trim from an off-by-one and shows that the upper bytes are ignored.
- A fast-mode setting with an uneven split. This exposes low and high values that have been swapped.
- A high-speed setting with a ratio of one. Here the two byte sets differ, so each switch to the second set, and each return to the first on STOP or on disable, shows as a change of measured length.

Invalid settings are held for a window to confirm that the line stays quiet. A disable in mid-phase shows that the counters restart from a clean high phase.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;
  typedef enum logic [1:0] {
    MODE_STD  = 2'd0,
    MODE_FAST = 2'd1,
    MODE_HS   = 2'd2,
    MODE_RSVD = 2'd3
  } scl_mode_e;
endpackage

// File: rtl/scl_psc.sv
module scl_psc #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  output logic             sample_tick
);
  logic [PSC_W-1:0] pcnt;

  assign sample_tick = run && (pcnt >= psc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pcnt <= '0;
    else if (!run)        pcnt <= '0;
    else if (sample_tick) pcnt <= '0;
    else                  pcnt <= pcnt + 1'b1;
  end

  // R2: a sampling tick restarts the divide count
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> (pcnt == '0));
  // R1: idle prescaler holds at zero
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pcnt == '0));
endmodule

// File: rtl/scl_phase_sel.sv
module scl_phase_sel
  import scl_tg_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int CFG_W = 2 * CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       mode,
  input  logic             psc_zero,
  input  logic [CFG_W-1:0] lo_cfg,
  input  logic [CFG_W-1:0] hi_cfg,
  input  logic             hs_data_go,
  input  logic             stop_seen,
  output logic [CNT_W-1:0] lo_val,
  output logic [CNT_W-1:0] hi_val,
  output logic             use_upper,
  output logic             cfg_err
);
  logic is_hs;

  function automatic logic [CNT_W-1:0] pick_byte(input logic [CFG_W-1:0] word,
                                                 input logic upper);
    return upper ? word[CFG_W-1:CNT_W] : word[CNT_W-1:0];
  endfunction

  assign is_hs  = (mode == MODE_HS);
  assign lo_val = pick_byte(lo_cfg, use_upper);
  assign hi_val = pick_byte(hi_cfg, use_upper);

  assign cfg_err = (mode == MODE_RSVD) || (lo_val == '0) || (hi_val == '0) ||
                   (psc_zero && !is_hs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            use_upper <= 1'b0;
    else if (!enable || !is_hs || stop_seen) use_upper <= 1'b0;
    else if (hs_data_go)                   use_upper <= 1'b1;
  end

  // R9: STOP returns to the first timing set
  p_stop_revert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !use_upper);
  // R7: second set never selected outside high-speed mode
  p_no_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !is_hs |=> !use_upper);
  // R8: selection only turns on after a go pulse
  p_go_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(use_upper) |-> $past(hs_data_go));
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
  parameter int CNT_W   = 8,
  parameter int LO_TRIM = 2,
  parameter int HI_TRIM = 1,
  localparam int LEN_W  = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             sample_tick,
  input  logic [CNT_W-1:0] lo_val,
  input  logic [CNT_W-1:0] hi_val,
  output logic             scl_low,
  output logic             tick_fall,
  output logic             tick_rise
);
  localparam logic [LEN_W-1:0] LO_T = LEN_W'(LO_TRIM);
  localparam logic [LEN_W-1:0] HI_T = LEN_W'(HI_TRIM);

  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] last_idx;
  logic             edge_now;

  // index of the final sampling tick of a phase: value + trim - 1
  function automatic logic [LEN_W-1:0] phase_last(input logic [CNT_W-1:0] v,
                                                  input logic [LEN_W-1:0] trim);
    return {1'b0, v} + trim - LEN_W'(1);
  endfunction

  assign last_idx = scl_low ? phase_last(lo_val, LO_T) : phase_last(hi_val, HI_T);
  assign edge_now = sample_tick && (cnt >= last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; scl_low <= 1'b0; tick_fall <= 1'b0; tick_rise <= 1'b0;
    end else if (!run) begin
      cnt <= '0; scl_low <= 1'b0; tick_fall <= 1'b0; tick_rise <= 1'b0;
    end else begin
      tick_fall <= 1'b0;
      tick_rise <= 1'b0;
      if (edge_now) begin
        cnt       <= '0;
        scl_low   <= !scl_low;
        tick_fall <= !scl_low;
        tick_rise <= scl_low;
      end else if (sample_tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R5: strobes are exclusive and match the line level
  p_tick_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_fall && tick_rise));
  p_fall_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fall |-> scl_low);
  p_rise_rel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |-> !scl_low);
  p_edge_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && (scl_low != $past(scl_low))) |-> (tick_fall || tick_rise));
  // R1 / R10 / R12: not running releases the line and silences ticks
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!scl_low && !tick_fall && !tick_rise));
  // R3 / R4: count never passes the longest possible phase
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LEN_W'((1 << CNT_W) - 1) + ((LO_T > HI_T) ? LO_T : HI_T));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tg_pkg::*;
#(
  parameter int PSC_W   = 8,
  parameter int CNT_W   = 8,
  parameter int LO_TRIM = 2,
  parameter int HI_TRIM = 1,
  localparam int CFG_W  = 2 * CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       mode,
  input  logic [PSC_W-1:0] psc,
  input  logic [CFG_W-1:0] lo_cfg,
  input  logic [CFG_W-1:0] hi_cfg,
  input  logic             hs_data_go,
  input  logic             stop_seen,
  output logic             scl_drive_low,
  output logic             tick_fall,
  output logic             tick_rise,
  output logic             cfg_err
);
  logic             run;
  logic             sample_tick;
  logic             use_upper;
  logic [CNT_W-1:0] lo_val;
  logic [CNT_W-1:0] hi_val;

  assign run = enable && !cfg_err;

  scl_phase_sel #(.CNT_W(CNT_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
    .psc_zero(psc == '0), .lo_cfg(lo_cfg), .hi_cfg(hi_cfg),
    .hs_data_go(hs_data_go), .stop_seen(stop_seen),
    .lo_val(lo_val), .hi_val(hi_val), .use_upper(use_upper), .cfg_err(cfg_err)
  );

  scl_psc #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .psc(psc), .sample_tick(sample_tick)
  );

  scl_phase_ctr #(.CNT_W(CNT_W), .LO_TRIM(LO_TRIM), .HI_TRIM(HI_TRIM)) u_ctr (
    .clk(clk), .rst_n(rst_n), .run(run), .sample_tick(sample_tick),
    .lo_val(lo_val), .hi_val(hi_val),
    .scl_low(scl_drive_low), .tick_fall(tick_fall), .tick_rise(tick_rise)
  );

  // R9: dropping enable clears the second-set selection
  p_dis_revert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !use_upper);
  // R10: an invalid setting never drives the line
  p_err_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && $past(cfg_err)) |-> !scl_drive_low);
endmodule

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;
  localparam int CLK_P = 10;
  localparam int LO_T  = 2;
  localparam int HI_T  = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [7:0]  psc = 8'd2;
  logic [15:0] lo_cfg = 16'h0004;
  logic [15:0] hi_cfg = 16'h0003;
  logic        hs_data_go = 1'b0;
  logic        stop_seen = 1'b0;
  logic        scl_drive_low, tick_fall, tick_rise, cfg_err;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int t0 = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scl_timing_gen u_scl_timing_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .psc(psc),
    .lo_cfg(lo_cfg), .hi_cfg(hi_cfg), .hs_data_go(hs_data_go),
    .stop_seen(stop_seen), .scl_drive_low(scl_drive_low),
    .tick_fall(tick_fall), .tick_rise(tick_rise), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // waits for a strobe (fall=1 / rise=0); returns the cycle stamp or -1
  task automatic wait_tick(input bit want_fall, output int at);
    at = -1;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      if (want_fall ? tick_fall : tick_rise) begin at = cyc; break; end
    end
  endtask

  task automatic measure(input string req, input int exp_lo, input int exp_hi);
    int tf, tr, tf2, bad_lvl;
    bad_lvl = 0;
    wait_tick(1'b1, tf);  if (!scl_drive_low) bad_lvl++;
    wait_tick(1'b0, tr);  if (scl_drive_low)  bad_lvl++;
    wait_tick(1'b1, tf2); if (!scl_drive_low) bad_lvl++;
    chk({req, " low length"},  tr - tf,  exp_lo);
    chk({req, " high length"}, tf2 - tr, exp_hi);
    chk({req, " R5 line level at strobes"}, bad_lvl, 0);
  endtask

  task automatic setup(input logic [1:0] m, input logic [7:0] p,
                       input logic [15:0] lo, input logic [15:0] hi);
    @(negedge clk);
    enable = 1'b0; mode = m; psc = p; lo_cfg = lo; hi_cfg = hi;
    @(negedge clk);
    enable = 1'b1;
    t0 = cyc;
  endtask

  task automatic pulse_go();
    @(negedge clk); hs_data_go = 1'b1; @(negedge clk); hs_data_go = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_seen = 1'b1; @(negedge clk); stop_seen = 1'b0;
  endtask

  // counts any line activity over n cycles
  task automatic quiet(input string req, input int n);
    int act;
    act = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (scl_drive_low || tick_fall || tick_rise) act++;
    end
    chk(req, act, 0);
  endtask

  task automatic t_reset();
    #(CLK_P/4);
    chk("R1 drive in reset", int'(scl_drive_low), 0);
    chk("R1 ticks in reset", int'(tick_fall | tick_rise), 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    quiet("R1 disabled stays released", 20);
  endtask

  task automatic t_std();
    int tf;
    setup(2'd0, 8'd2, 16'hAB04, 16'hCD03);
    wait_tick(1'b1, tf);
    chk("R6 first fall after high phase", tf - t0, (3 + HI_T) * 3);
    measure("R3 R4 R2 standard", (4 + LO_T) * 3, (3 + HI_T) * 3);
    pulse_go();
    measure("R7 upper bytes and go ignored", (4 + LO_T) * 3, (3 + HI_T) * 3);
  endtask

  task automatic t_fast();
    setup(2'd1, 8'd1, 16'h0006, 16'h0002);
    chk("R10 fast valid no err", int'(cfg_err), 0);
    measure("R3 R4 fast split", (6 + LO_T) * 2, (2 + HI_T) * 2);
  endtask

  task automatic t_hs();
    int tf;
    setup(2'd2, 8'd0, 16'h0503, 16'h0402);
    #1 chk("R11 hs psc zero valid", int'(cfg_err), 0);
    wait_tick(1'b1, tf);
    chk("R11 R6 hs first fall", tf - t0, 2 + HI_T);
    measure("R8 hs first set", 3 + LO_T, 2 + HI_T);
    pulse_go();
    measure("R8 hs second set", 5 + LO_T, 4 + HI_T);
    pulse_stop();
    measure("R9 stop reverts", 3 + LO_T, 2 + HI_T);
    pulse_go();
    measure("R8 second set again", 5 + LO_T, 4 + HI_T);
    @(negedge clk); enable = 1'b0;
    @(negedge clk); enable = 1'b1; t0 = cyc;
    wait_tick(1'b1, tf);
    chk("R9 disable reverts first fall", tf - t0, 2 + HI_T);
    measure("R9 disable reverts lengths", 3 + LO_T, 2 + HI_T);
  endtask

  task automatic t_err();
    setup(2'd0, 8'd2, 16'h0500, 16'h0003);
    #1 chk("R10 zero low byte flags", int'(cfg_err), 1);
    quiet("R10 zero low byte quiet", 40);
    setup(2'd1, 8'd2, 16'h0004, 16'h0700);
    #1 chk("R10 zero high byte flags", int'(cfg_err), 1);
    quiet("R10 zero high byte quiet", 40);
    setup(2'd0, 8'd0, 16'h0004, 16'h0003);
    #1 chk("R10 psc zero in standard flags", int'(cfg_err), 1);
    quiet("R10 psc zero quiet", 40);
    setup(2'd3, 8'd2, 16'h0004, 16'h0003);
    #1 chk("R10 reserved mode flags", int'(cfg_err), 1);
    quiet("R10 reserved mode quiet", 40);
  endtask

  task automatic t_disable();
    int tf;
    setup(2'd0, 8'd2, 16'h0004, 16'h0003);
    wait_tick(1'b1, tf);
    repeat (5) @(posedge clk);
    @(negedge clk); enable = 1'b0;
    @(posedge clk); #1;
    chk("R12 released after disable", int'(scl_drive_low), 0);
    @(negedge clk); enable = 1'b1; t0 = cyc;
    wait_tick(1'b1, tf);
    chk("R12 restart with full high", tf - t0, (3 + HI_T) * 3);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_std();
    t_fast();
    t_hs();
    t_err();
    t_disable();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule